// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is the byte-level control core of an I2C master. Software programs a control word, a byte count and a 16-entry data queue through a small write port. It then starts a transfer by writing the target address. The sequencer steps through the start condition, the address phase, the data bytes and the stop condition. It passes each step as a command to a separate bit-level engine, which generates the SCL/SDA timing and reports back the acknowledge bit and any received byte.

In transmit mode, bytes are drained from the queue until it runs dry. In receive mode, the byte count decides how many bytes are read, and the last byte read is answered with NACK. A hold bit keeps the bus owned between transfers, so no stop is issued and a repeated start can follow. While hold is set, an empty queue in transmit mode stalls the transfer and leaves the bus owned. An address NACK or data NACK from the slave aborts the transfer.

Top module: `i2c_byte_seq`

## Requirements
- R1: An address write (`wr_sel`=1) starts a transfer only while control bit 1 (master enable) is 1; otherwise it has no effect on the bus.
- R2: With control bit 2 = 1 (7-bit addressing), a transfer issues START, then WRITE of {addr[6:0], dir}, then the data bytes. In transmit mode, the queued bytes are written in the order they were queued, and STOP is issued once the queue is empty and hold is clear. Command codes: 0 START, 1 STOP, 2 WRITE, 3 READ.
- R3: With control bit 2 = 0 (10-bit addressing), the address phase is WRITE of {5'b11110, addr[9:8], dir} followed by WRITE of addr[7:0].
- R4: With control bit 0 = 1 (receive), one READ is issued per remaining count, and each received byte is queued. The count goes down by one per byte. A READ is flagged NACK (`cmd_nack`=1) exactly when it is the last one (count 1), and no READ is issued at count 0.
- R5: In receive mode, no READ is issued while the queue holds 16 bytes. Reading resumes after software pops a byte.
- R6: With control bit 4 (hold) set, a transmit transfer whose queue is empty stalls without STOP and resumes when a byte is queued. A receive transfer ends without STOP. In both cases `bus_active` stays 1. Clearing hold then issues STOP.
- R7: A NACK on an address or transmitted byte aborts the transfer. It produces a one-cycle `nack_evt` pulse and issues STOP unless hold is set.
- R8: Writing a control word with bit 6 = 1 empties the queue; the bit is not stored.
- R9: `size_count` reports queue occupancy when control bit 0 = 0 and the remaining receive count when it is 1. `rx_valid` is 1 in receive mode while the queue is non-empty, and `rd_data` shows the oldest byte.
- R10: The queue holds at most 16 bytes; a data write (`wr_sel`=3) to a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 address, 2 byte count, 3 data |
| wr_data | input | 16 | Write value |
| rd_pop | input | 1 | Removes the oldest received byte |
| rd_data | output | 8 | Oldest queued byte |
| rx_valid | output | 1 | Received data available |
| bus_active | output | 1 | Bus owned by this master |
| size_count | output | 8 | Queue occupancy (transmit) or remaining count (receive) |
| nack_evt | output | 1 | One-cycle pulse on an abort caused by NACK |
| cmd_valid | output | 1 | Command presented to the bit engine |
| cmd_code | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_byte | output | 8 | Byte to write |
| cmd_nack | output | 1 | Answer this READ with NACK |
| eng_done | input | 1 | Bit engine finished the command (one-cycle pulse) |
| eng_nack | input | 1 | Slave answered NACK (valid with eng_done) |
| eng_rx_byte | input | 8 | Byte read (valid with eng_done) |

## Verification
A wrong queue pointer or count would show at `size_count`, `rx_valid` or `rd_data` within one cycle of the push or pop that disturbed it. For that reason, those ports are compared against a behavioural queue on every clock. A wrong sequencer state shows up as a command stream that differs from the expected one, or as `bus_active` staying high or dropping at the wrong time. Each transfer's logged command list is compared entry by entry once the transfer settles, and that covers start, address encoding, NACK flagging, stall and stop.

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = 10,
  parameter int SW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [15:0]   wr_data,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  output logic          rx_valid,
  output logic          bus_active,
  output logic [SW-1:0] size_count,
  output logic          nack_evt,
  output logic          cmd_valid,
  output logic [1:0]    cmd_code,
  output logic [7:0]    cmd_byte,
  output logic          cmd_nack,
  input  logic          eng_done,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rx_byte
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR1, S_ADDR2, S_DATA, S_STOP} st_t;
  st_t state;

  logic c_dir, c_ms, c_norm, c_hold;
  logic xdir, tenbit, owned;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] count;

  wire wr_ctrl = wr_en && wr_sel == 2'd0;
  wire wr_addr = wr_en && wr_sel == 2'd1;
  wire wr_size = wr_en && wr_sel == 2'd2;
  wire wr_dat  = wr_en && wr_sel == 2'd3;
  wire clr     = wr_ctrl && wr_data[6];
  wire empty   = count == '0;
  wire full    = count == CW'(DEPTH);
  wire in_data = state == S_DATA;

  wire eng_push = in_data && xdir && eng_done;
  wire eng_pop  = in_data && !xdir && eng_done && !empty;
  wire sw_push  = wr_dat && !c_dir && !full;
  wire sw_pop   = rd_pop && c_dir && !empty;
  wire push     = eng_push || sw_push;
  wire pop      = eng_pop || sw_pop;
  wire tx_stall = in_data && !xdir && empty && c_hold;
  wire launch   = wr_addr && c_ms && (state == S_IDLE || tx_stall);

  assign rd_data    = mem[rp];
  assign rx_valid   = c_dir && !empty;
  assign bus_active = state != S_IDLE || owned;
  assign size_count = c_dir ? size_q : SW'(count);

  always_comb begin
    cmd_valid = 1'b1;
    cmd_code  = C_WRITE;
    cmd_byte  = 8'h00;
    cmd_nack  = 1'b0;
    unique case (state)
      S_IDLE:  cmd_valid = 1'b0;
      S_START: cmd_code = C_START;
      S_STOP:  cmd_code = C_STOP;
      S_ADDR1: cmd_byte = tenbit ? {5'b11110, addr_q[9:8], xdir} : {addr_q[6:0], xdir};
      S_ADDR2: cmd_byte = addr_q[7:0];
      default: if (xdir) begin
        cmd_code  = C_READ;
        cmd_valid = size_q != '0 && !full;
        cmd_nack  = size_q == SW'(1);
      end else begin
        cmd_valid = !empty;
        cmd_byte  = mem[rp];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      rp <= '0; wp <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= eng_push ? eng_rx_byte : wr_data[7:0];
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_dir, c_ms, c_norm, c_hold} <= '0;
      state <= S_IDLE; xdir <= 1'b0; tenbit <= 1'b0; owned <= 1'b0;
      addr_q <= '0; size_q <= '0; nack_evt <= 1'b0;
    end else begin
      nack_evt <= 1'b0;
      if (wr_ctrl) {c_hold, c_norm, c_ms, c_dir} <= {wr_data[4], wr_data[2], wr_data[1], wr_data[0]};
      if (wr_size) size_q <= wr_data[SW-1:0];
      else if (eng_push) size_q <= size_q - 1'b1;
      if (launch) begin
        state <= S_START; addr_q <= wr_data[AW-1:0];
        xdir <= c_dir; tenbit <= !c_norm; owned <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE:  if (owned && !c_hold) state <= S_STOP;
          S_START: if (eng_done) state <= S_ADDR1;
          S_ADDR1, S_ADDR2:
            if (eng_done) begin
              if (eng_nack) begin
                nack_evt <= 1'b1;
                state <= c_hold ? S_IDLE : S_STOP;
                owned <= c_hold;
              end else state <= (state == S_ADDR1 && tenbit) ? S_ADDR2 : S_DATA;
            end
          S_DATA:
            if (xdir) begin
              if (size_q == '0) begin
                state <= c_hold ? S_IDLE : S_STOP;
                owned <= c_hold;
              end
            end else if (empty) begin
              if (!c_hold) state <= S_STOP;
            end else if (eng_done && eng_nack) begin
              nack_evt <= 1'b1;
              state <= c_hold ? S_IDLE : S_STOP;
              owned <= c_hold;
            end
          default: if (eng_done) begin state <= S_IDLE; owned <= 1'b0; end
        endcase
      end
    end
  end

  p_fifo_bound_r10: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !eng_done && !wr_en |=> cmd_valid && $stable(cmd_code) && $stable(cmd_byte));
  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt && !c_hold && !$past(wr_en) |-> cmd_valid && cmd_code == C_STOP);
  p_nack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) nack_evt |=> !nack_evt);
  p_read_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == C_READ |-> size_q != '0 && !full);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n) !bus_active |-> !cmd_valid);
endmodule

// File: tb/i2c_byte_seq_bench.sv
module i2c_byte_seq_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_pop = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] rd_data, cmd_byte, size_count;
  logic rx_valid, bus_active, nack_evt, cmd_valid, cmd_nack;
  logic [1:0] cmd_code;
  logic eng_done = 0, eng_nack = 0;
  logic [7:0] eng_rx_byte = 0;

  int total = 0, bad = 0, cycles = 0, nack_cnt = 0, nack_at = -1, lat = 0;
  logic [7:0] rxval = 8'h40;
  logic [10:0] logq[$], expq[$];
  logic [7:0] q[$];
  logic m_dir = 0, m_norm = 0;
  int addr_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_seq u_i2c_byte_seq (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .rd_pop, .rd_data,
    .rx_valid, .bus_active, .size_count, .nack_evt, .cmd_valid, .cmd_code, .cmd_byte,
    .cmd_nack, .eng_done, .eng_nack, .eng_rx_byte);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // bit engine model: answers each command after three cycles and logs it
  always @(posedge clk) begin
    if (cmd_valid && !eng_done) begin
      if (lat == 2) begin
        eng_done <= 1; lat <= 0;
        eng_nack <= (logq.size() == nack_at);
        logq.push_back(cmd_code == 2'd3 ? {cmd_nack, 2'd3, 8'h00} : {1'b0, cmd_code, cmd_byte});
        if (cmd_code == 2'd3) begin eng_rx_byte <= rxval; rxval <= rxval + 1; end
      end else lat <= lat + 1;
    end else begin eng_done <= 0; lat <= 0; end
    if (nack_evt) nack_cnt++;
  end

  // behavioural queue model
  always @(posedge clk) if (rst_n) begin
    int n; n = q.size();
    if (wr_en && wr_sel == 0) begin
      m_dir = wr_data[0]; m_norm = wr_data[2];
      if (wr_data[6]) q.delete();
    end else begin
      bit do_pop; logic [7:0] pb; bit do_push;
      do_pop = 0; do_push = 0;
      if (eng_done && cmd_code == 2'd0) addr_left = m_norm ? 1 : 2;
      if (eng_done && cmd_code == 2'd2) begin
        if (addr_left > 0) addr_left--; else if (n > 0) do_pop = 1;
      end
      if (rd_pop && m_dir && n > 0) do_pop = 1;
      if (wr_en && wr_sel == 3 && !m_dir && n < 16) begin do_push = 1; pb = wr_data[7:0]; end
      if (eng_done && cmd_code == 2'd3) begin do_push = 1; pb = eng_rx_byte; end
      if (do_pop) void'(q.pop_front());
      if (do_push) q.push_back(pb);
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (!m_dir) check(size_count == 8'(q.size()), "R9 occupancy", size_count, q.size());
    else begin
      check(rx_valid == (q.size() != 0), "R9 rx_valid", rx_valid, q.size() != 0);
      if (q.size() != 0) check(rd_data == q[0], "R4 rx byte", rd_data, q[0]);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic pop1();
    @(negedge clk); rd_pop = 1; @(negedge clk); rd_pop = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 2000 && bus_active; i++) @(negedge clk);
  endtask
  task automatic ex(input logic [1:0] c, input logic [7:0] b, input logic nk);
    expq.push_back({nk, c, b});
  endtask
  int lp = 0;
  task automatic check_log(input string tag);
    check(logq.size() == lp + expq.size(), {tag, " log length"}, logq.size() - lp, expq.size());
    if (logq.size() == lp + expq.size())
      foreach (expq[i]) check(logq[lp + i] == expq[i], {tag, " command"}, logq[lp + i], expq[i]);
    lp = logq.size(); expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    check(!bus_active && !cmd_valid && !rx_valid && size_count == 0, "R9 reset", bus_active, 0);

    // R2 7-bit transmit
    wr(0, 16'h0006); wr(3, 16'hAA); wr(3, 16'hBB); wr(3, 16'hCC); wr(1, 16'h052);
    repeat (5) @(negedge clk); wait_idle();
    ex(0,0,0); ex(2,8'hA4,0); ex(2,8'hAA,0); ex(2,8'hBB,0); ex(2,8'hCC,0); ex(1,0,0);
    check_log("R2");

    // R3 10-bit transmit
    wr(0, 16'h0002); wr(3, 16'h11); wr(1, 16'h2C5);
    repeat (5) @(negedge clk); wait_idle();
    ex(0,0,0); ex(2,8'hF4,0); ex(2,8'hC5,0); ex(2,8'h11,0); ex(1,0,0);
    check_log("R3");

    // R4 receive three bytes
    wr(0, 16'h0007); wr(2, 16'd3); wr(1, 16'h033);
    repeat (5) @(negedge clk); wait_idle();
    ex(0,0,0); ex(2,8'h67,0); ex(3,0,0); ex(3,0,0); ex(3,0,1); ex(1,0,0);
    check_log("R4");
    check(size_count == 0, "R4 count drained", size_count, 0);
    check(rd_data == 8'h40 && rx_valid, "R4 first byte", rd_data, 8'h40);
    repeat (3) pop1();
    check(!rx_valid, "R9 rx empty", rx_valid, 0);

    // R7 address NACK, then R8 clear
    wr(0, 16'h0006); wr(3, 16'h01);
    nack_at = logq.size() + 1; wr(1, 16'h052);
    repeat (5) @(negedge clk); wait_idle(); nack_at = -1;
    ex(0,0,0); ex(2,8'hA4,0); ex(1,0,0);
    check_log("R7");
    check(nack_cnt == 1, "R7 nack pulse count", nack_cnt, 1);
    check(size_count == 1, "R7 byte kept", size_count, 1);
    wr(0, 16'h0046);
    check(size_count == 0, "R8 clear", size_count, 0);

    // R6 hold in transmit
    wr(0, 16'h0016); wr(3, 16'h21); wr(3, 16'h22); wr(1, 16'h010);
    repeat (40) @(negedge clk);
    ex(0,0,0); ex(2,8'h20,0); ex(2,8'h21,0); ex(2,8'h22,0);
    check_log("R6 stall");
    check(bus_active && !cmd_valid, "R6 owned while stalled", bus_active, 1);
    wr(3, 16'h23); repeat (20) @(negedge clk);
    ex(2,8'h23,0); check_log("R6 resume");
    wr(0, 16'h0006); repeat (5) @(negedge clk); wait_idle();
    ex(1,0,0); check_log("R6 stop");
    check(!bus_active, "R6 released", bus_active, 0);

    // R5 receive stall on full queue
    wr(0, 16'h0007); wr(2, 16'd18); wr(1, 16'h033);
    repeat (250) @(negedge clk);
    check(bus_active && !cmd_valid, "R5 stalled", cmd_valid, 0);
    check(size_count == 2, "R5 remaining", size_count, 2);
    for (int i = 0; i < 16; i++) pop1();
    repeat (5) @(negedge clk); wait_idle();
    ex(0,0,0); ex(2,8'h67,0);
    for (int i = 0; i < 17; i++) ex(3,0,0);
    ex(3,0,1); ex(1,0,0);
    check_log("R5");
    repeat (2) pop1();

    // R1 master disabled
    wr(0, 16'h0004); wr(1, 16'h052); repeat (20) @(negedge clk);
    check(!bus_active, "R1 no start", bus_active, 0);
    check_log("R1");

    // R6 hold in receive
    wr(0, 16'h0017); wr(2, 16'd2); wr(1, 16'h033);
    repeat (60) @(negedge clk);
    ex(0,0,0); ex(2,8'h67,0); ex(3,0,0); ex(3,0,1);
    check_log("R6 rx hold");
    check(bus_active && !cmd_valid, "R6 rx owned", bus_active, 1);
    wr(0, 16'h0007); repeat (5) @(negedge clk); wait_idle();
    ex(1,0,0); check_log("R6 rx stop");
    repeat (2) pop1();

    // R10 overfull write dropped
    wr(0, 16'h0046);
    for (int i = 0; i < 17; i++) wr(3, 16'(8'h80 + i));
    check(size_count == 16, "R10 depth", size_count, 16);
    wr(1, 16'h052); repeat (5) @(negedge clk); wait_idle();
    ex(0,0,0); ex(2,8'hA4,0);
    for (int i = 0; i < 16; i++) ex(2, 8'(8'h80 + i), 0);
    ex(1,0,0); check_log("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule